// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple single-word request port and a two-bank SDR SDRAM array clocked at 100 MHz with CAS latency 3. It brings the memory up after reset, keeps it refreshed, and turns each user request into an Activate followed three cycles later by a Read or Write with auto-precharge, so every access is a closed-page single-word transfer.

On the user side a requester holds `usr_req` with the address, direction, write data and byte enables until it sees a one-cycle `usr_ack`; read data comes back later with a one-cycle `usr_rvalid`. On the memory side every command is registered, and all spacing rules are fixed cycle counts derived from 10 ns timing values.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the memory command is NOP (chip select low, RAS/CAS/WE high), clock enable is high, all byte masks are high, the data bus is not driven, and `usr_ack`/`usr_rvalid` are low.
- R2: After reset, at least 10000 NOP cycles pass before a Precharge with A10 high; then exactly 8 Refresh commands are issued, the first at least 3 cycles after the precharge and each following one at least 8 cycles after the previous, before any Mode Register Set.
- R3: The mode word on A10..A0 is 0x030 (A6:A4 = 011 for latency 3, A3 = 0 sequential, A2:A0 = 000 for one word) with bank select 0, and the next command follows it by at least 2 cycles.
- R4: `usr_addr[20]` is the bank, `usr_addr[19:9]` the row and `usr_addr[8:0]` the column; the row appears on A10..A0 with the Activate, the column on A8..A0 with the Read or Write, and A10 is high on every Read and Write (auto-precharge).
- R5: A Read or Write comes exactly 3 cycles after its Activate; Activates are at least 8 cycles apart and at least 5 cycles after the previous Read or Write.
- R6: `usr_ack` is a one-cycle pulse in exactly the cycle the Activate for that request is on the command pins.
- R7: In the Write cycle the data bus is driven with the request's write data and the byte masks equal the inverted byte enables (mask bit i high blocks byte i); the bus is driven in no other cycle.
- R8: The byte masks are low in the cycle after a Read; `usr_rvalid` pulses 4 cycles after the Read command cycle, carrying the data sampled from the memory 3 cycles after the Read.
- R9: After initialisation one Refresh is issued about every 1560 cycles, and no Activate or Refresh follows a Refresh by fewer than 8 cycles.
- R10: A pending refresh wins over a pending user request; under continuous requests refreshes are still issued while `usr_req` is high and unacknowledged.
- R11: Every cycle without another command carries NOP, only legal command codes appear, and clock enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| usr_req | input | 1 | Request, held until acknowledged |
| usr_we | input | 1 | 1 = write, 0 = read |
| usr_addr | input | 21 | {bank, row, column} word address |
| usr_wdata | input | 64 | Write data |
| usr_be | input | 8 | Byte enables for a write |
| usr_ack | output | 1 | Request accepted (one cycle) |
| usr_rdata | output | 64 | Read data |
| usr_rvalid | output | 1 | Read data valid (one cycle) |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_a | output | 11 | Multiplexed row/column/mode address |
| mem_ba | output | 1 | Bank select |
| mem_dqm | output | 8 | Byte masks |
| mem_dq_out | output | 64 | Data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 64 | Data from memory |

## Verification
The bench aims at the read return window: a controller that captured one cycle early or late would return the stale bus value and the data comparison against a byte-accurate memory model fails. It overwrites half of a word with a partial byte-enable write, which exposes inverted or shifted masks as a wrong merged word on read-back. It uses the highest row, column and bank to catch field slicing errors, and runs unbroken request traffic across a refresh interval so that a controller favouring requests never refreshes, while a command monitor flags any Activate, Refresh or Read/Write placed inside a forbidden spacing.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int ROW_W   = 11;
    localparam int COL_W   = 9;
    localparam int BANK_W  = 1;
    localparam int A_W     = 11;
    localparam int DATA_W  = 64;
    localparam int BYTE_N  = DATA_W / 8;
    localparam int UADDR_W = BANK_W + ROW_W + COL_W;

    // Fixed spacings in 10 ns cycles
    localparam int T_INIT    = 10000; // 100 us power-up pause
    localparam int T_RP      = 3;
    localparam int T_RCD     = 3;
    localparam int T_RC      = 8;
    localparam int T_MRD     = 2;
    localparam int T_RW_NEXT = 5;     // read/write with auto-precharge to next command
    localparam int REF_INT   = 1560;
    localparam int INIT_REFS = 8;
    localparam int CAS_LAT   = 3;

    localparam int CNT_W  = $clog2(T_INIT) + 1;
    localparam int REF_W  = $clog2(REF_INT);
    localparam int IREF_W = $clog2(INIT_REFS) + 1;

    // latency 3, sequential, one-word bursts
    localparam logic [A_W-1:0] MODE_WORD = 11'b000_0_011_0_000;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT, ST_PRE_ALL, ST_INIT_REF, ST_MRS, ST_IDLE, ST_RW
    } st_e;

    typedef struct packed {
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [BYTE_N-1:0] be;
    } ureq_t;

    // counter preload giving the next command n cycles after the current one
    function automatic logic [CNT_W-1:0] gap_load(input int n);
        return CNT_W'(n - 2);
    endfunction
endpackage

// File: rtl/sdc_wait_timer.sv
module sdc_wait_timer
    import sdc_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = gap_load(T_INIT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= RST_VAL;
        else if (load)  cnt <= load_val;
        else if (!zero) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_WAIT_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1)); // R5
endmodule

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer
    import sdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic taken,
    output logic pending
);
    logic [REF_W-1:0] cnt;
    logic             tick;

    assign tick = run && (cnt == REF_W'(REF_INT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (run) cnt <= tick ? '0 : cnt + 1'b1;
            pending <= tick | (pending & ~taken);
        end
    end

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (rst)
        (pending && !taken) |=> pending); // R10
endmodule

// File: rtl/sdc_rd_capture.sv
module sdc_rd_capture
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_rd,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [CAS_LAT-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe   <= '0;
            rvalid <= 1'b0;
        end else begin
            pipe   <= {pipe[CAS_LAT-2:0], issue_rd};
            rvalid <= pipe[CAS_LAT-1];
        end
    end

    always_ff @(posedge clk) begin
        if (pipe[CAS_LAT-1]) rdata <= dq_in;
    end

    AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(issue_rd, CAS_LAT + 1)); // R8
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               usr_req,
    input  logic               usr_we,
    input  logic [UADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0]  usr_wdata,
    input  logic [BYTE_N-1:0]  usr_be,
    output logic               usr_ack,
    output logic [DATA_W-1:0]  usr_rdata,
    output logic               usr_rvalid,
    output logic               mem_cke,
    output logic               mem_cs_n,
    output logic               mem_ras_n,
    output logic               mem_cas_n,
    output logic               mem_we_n,
    output logic [A_W-1:0]     mem_a,
    output logic [BANK_W-1:0]  mem_ba,
    output logic [BYTE_N-1:0]  mem_dqm,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in
);
    st_e               state, target;
    cmd_e              cmd_q;
    ureq_t             req_q;
    logic [IREF_W-1:0] init_refs;
    logic              init_done, rd_flag, cke_q;
    logic              tmr_load, tmr_zero, ref_pend, ref_take;
    logic [CNT_W-1:0]  tmr_val;

    // timer preload chosen by the command issued this cycle
    always_comb begin
        tmr_load = (state != ST_WAIT);
        unique case (state)
            ST_PRE_ALL:  tmr_val = gap_load(T_RP);
            ST_INIT_REF: tmr_val = gap_load(T_RC);
            ST_MRS:      tmr_val = gap_load(T_MRD);
            ST_IDLE:     tmr_val = ref_pend ? gap_load(T_RC) : gap_load(T_RCD);
            ST_RW:       tmr_val = gap_load(T_RW_NEXT);
            default:     tmr_val = '0;
        endcase
    end

    assign ref_take = (state == ST_IDLE) && ref_pend;

    sdc_wait_timer #(.RST_VAL(gap_load(T_INIT))) i_wait (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sdc_refresh_timer i_refresh (
        .clk(clk), .rst(rst), .run(init_done), .taken(ref_take), .pending(ref_pend)
    );

    sdc_rd_capture i_capture (
        .clk(clk), .rst(rst), .issue_rd(cmd_q == CMD_RD), .dq_in(mem_dq_in),
        .rdata(usr_rdata), .rvalid(usr_rvalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_WAIT;
            target     <= ST_PRE_ALL;
            cmd_q      <= CMD_NOP;
            mem_a      <= '0;
            mem_ba     <= '0;
            mem_dqm    <= '1;
            mem_dq_oe  <= 1'b0;
            mem_dq_out <= '0;
            usr_ack    <= 1'b0;
            init_refs  <= '0;
            init_done  <= 1'b0;
            rd_flag    <= 1'b0;
            cke_q      <= 1'b1;
            req_q      <= '0;
        end else begin
            cmd_q     <= CMD_NOP;
            usr_ack   <= 1'b0;
            mem_dq_oe <= 1'b0;
            mem_dqm   <= (state == ST_WAIT && rd_flag) ? '0 : '1;
            unique case (state)
                ST_WAIT: if (tmr_zero) state <= target;
                ST_PRE_ALL: begin
                    cmd_q  <= CMD_PRE;
                    mem_a  <= A_W'(1) << 10;
                    state  <= ST_WAIT;
                    target <= ST_INIT_REF;
                end
                ST_INIT_REF: begin
                    cmd_q     <= CMD_REF;
                    init_refs <= init_refs + 1'b1;
                    state     <= ST_WAIT;
                    target    <= (init_refs == IREF_W'(INIT_REFS - 1)) ? ST_MRS : ST_INIT_REF;
                end
                ST_MRS: begin
                    cmd_q     <= CMD_MRS;
                    mem_a     <= MODE_WORD;
                    mem_ba    <= '0;
                    init_done <= 1'b1;
                    state     <= ST_WAIT;
                    target    <= ST_IDLE;
                end
                ST_IDLE: begin
                    rd_flag <= 1'b0;
                    if (ref_pend) begin
                        cmd_q  <= CMD_REF;
                        state  <= ST_WAIT;
                        target <= ST_IDLE;
                    end else if (usr_req) begin
                        cmd_q   <= CMD_ACT;
                        usr_ack <= 1'b1;
                        req_q   <= '{we: usr_we,
                                     bank: usr_addr[UADDR_W-1 -: BANK_W],
                                     row: usr_addr[COL_W +: ROW_W],
                                     col: usr_addr[COL_W-1:0],
                                     wdata: usr_wdata, be: usr_be};
                        mem_a   <= usr_addr[COL_W +: ROW_W];
                        mem_ba  <= usr_addr[UADDR_W-1 -: BANK_W];
                        state   <= ST_WAIT;
                        target  <= ST_RW;
                    end
                end
                ST_RW: begin
                    cmd_q   <= req_q.we ? CMD_WR : CMD_RD;
                    mem_a   <= {1'b1, {(A_W-1-COL_W){1'b0}}, req_q.col};
                    rd_flag <= !req_q.we;
                    if (req_q.we) begin
                        mem_dq_out <= req_q.wdata;
                        mem_dq_oe  <= 1'b1;
                        mem_dqm    <= ~req_q.be;
                    end else begin
                        mem_dqm    <= '0;
                    end
                    state  <= ST_WAIT;
                    target <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
    assign mem_cke = cke_q;

    AST_ACK_ON_ACTIVATE: assert property (@(posedge clk) disable iff (rst)
        usr_ack |-> (cmd_q == CMD_ACT)); // R6
    AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> mem_a[10]); // R4
    AST_ACT_TO_COLUMN: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> ($past(cmd_q, T_RCD) == CMD_ACT)); // R5
    AST_BUS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (cmd_q == CMD_WR)); // R7
    AST_READ_MASK_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_RD) |=> (mem_dqm == '0)); // R8
endmodule

// File: tb/test_sdram_cmd_ctrl.sv
module test_sdram_cmd_ctrl;
    import sdc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic usr_req = 1'b0, usr_we = 1'b0;
    logic [UADDR_W-1:0] usr_addr = '0;
    logic [DATA_W-1:0]  usr_wdata = '0;
    logic [BYTE_N-1:0]  usr_be = '0;
    logic usr_ack, usr_rvalid;
    logic [DATA_W-1:0] usr_rdata;
    logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
    logic [A_W-1:0] mem_a;
    logic [BANK_W-1:0] mem_ba;
    logic [BYTE_N-1:0] mem_dqm;
    logic [DATA_W-1:0] mem_dq_out;
    logic [DATA_W-1:0] mem_dq_in = '0;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    sdram_cmd_ctrl i_sdram_cmd_ctrl (.*);

    logic [3:0] cmd;
    assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // ---------------- memory model and command monitor ----------------
    logic [63:0] mdl [int];
    logic [63:0] expm [int];
    logic [ROW_W-1:0] open_row [2];
    logic [3:0]  rp_v = '0;
    logic [63:0] rp_d [4];
    int cyc = 0;
    int last_act = -1000, last_ref = -1000, last_rw = -1000, last_pre = -1000, last_rd = -1000;
    int mrs_cyc = -1000, pre_cyc = -1, ref_cnt = 0, init_refs = 0, ref_with_req = 0;
    bit mrs_seen = 0, pre_a10 = 0;
    logic [A_W-1:0] mrs_a = '0;
    logic [BANK_W-1:0] mrs_ba = '0;
    int vio_r3 = 0, vio_r4 = 0, vio_r5 = 0, vio_r6 = 0, vio_r7 = 0, vio_r8 = 0, vio_r9 = 0, vio_r11 = 0;

    always @(negedge clk) begin
        for (int s = 3; s > 0; s--) begin
            rp_v[s] = rp_v[s-1];
            rp_d[s] = rp_d[s-1];
        end
        rp_v[0] = 1'b0;
        if (!rst) begin
            int k;
            k = int'({mem_ba, open_row[mem_ba], mem_a[COL_W-1:0]});
            if (!mem_cke) vio_r11++;
            if (!(cmd inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111})) vio_r11++;
            if (mem_dq_oe && cmd != 4'b0100) vio_r7++;
            if (usr_ack && cmd != 4'b0011) vio_r6++;
            if (usr_rvalid != (cyc == last_rd + 4)) vio_r8++;
            case (cmd)
                4'b0011: begin
                    if (cyc - last_act < 8 || cyc - last_rw < 5) vio_r5++;
                    if (cyc - last_ref < 8) vio_r9++;
                    if (cyc - mrs_cyc < 2) vio_r3++;
                    if (!usr_ack) vio_r6++;
                    open_row[mem_ba] = mem_a;
                    last_act = cyc;
                end
                4'b0100, 4'b0101: begin
                    if (cyc - last_act != 3) vio_r5++;
                    if (!mem_a[10]) vio_r4++;
                    if (cmd == 4'b0100) begin
                        logic [63:0] w;
                        w = mdl.exists(k) ? mdl[k] : 64'h0;
                        for (int b = 0; b < BYTE_N; b++)
                            if (!mem_dqm[b]) w[8*b +: 8] = mem_dq_out[8*b +: 8];
                        mdl[k] = w;
                    end else begin
                        rp_v[0] = 1'b1;
                        rp_d[0] = mdl.exists(k) ? mdl[k] : 64'h0;
                        last_rd = cyc;
                    end
                    last_rw = cyc;
                end
                4'b0001: begin
                    if (cyc - last_act < 8 || cyc - last_ref < 8 || cyc - last_rw < 5 || cyc - last_pre < 3) vio_r9++;
                    if (cyc - mrs_cyc < 2) vio_r3++;
                    ref_cnt++;
                    if (!mrs_seen) init_refs++;
                    else if (usr_req) ref_with_req++;
                    last_ref = cyc;
                end
                4'b0010: begin
                    pre_cyc = cyc; pre_a10 = mem_a[10]; last_pre = cyc;
                end
                4'b0000: begin
                    if (cyc - last_ref < 8) vio_r9++;
                    mrs_seen = 1; mrs_cyc = cyc; mrs_a = mem_a; mrs_ba = mem_ba;
                end
                default: ;
            endcase
            cyc++;
        end
        mem_dq_in = rp_v[3] ? rp_d[3] : 64'hBAD0_BAD0_BAD0_BAD0;
    end

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(cmd == 4'b0111 && mem_cke, "R1", "cmd/cke in reset", {cmd, 3'b0, mem_cke}, 64'h71);
        chk(!usr_ack && !usr_rvalid && !mem_dq_oe, "R1", "ack/rvalid/oe in reset",
            {usr_ack, usr_rvalid, mem_dq_oe}, 0);
        chk(mem_dqm == '1, "R1", "dqm in reset", mem_dqm, 8'hFF);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd == 4'b0111 && mem_dqm == '1, "R1", "first cycle after reset", {cmd, mem_dqm}, 12'h7FF);
    endtask

    task automatic t_init();
        for (int n = 0; n < 20000 && !mrs_seen; n++) @(negedge clk);
        chk(pre_cyc >= T_INIT && pre_a10, "R2", "precharge-all timing", pre_cyc, T_INIT);
        chk(init_refs == INIT_REFS, "R2", "refreshes before mode set", init_refs, INIT_REFS);
        chk(mrs_a == 11'h030 && mrs_ba == '0, "R3", "mode word", {mrs_ba, mrs_a}, 12'h030);
    endtask

    task automatic wait_ack();
        int n = 0;
        do begin @(negedge clk); n++; end while (!usr_ack && n < 3000);
    endtask

    task automatic t_write(input logic [UADDR_W-1:0] ad, input logic [63:0] d, input logic [7:0] be);
        int k = int'(ad);
        logic [63:0] w;
        @(negedge clk);
        usr_req = 1; usr_we = 1; usr_addr = ad; usr_wdata = d; usr_be = be;
        wait_ack();
        chk(usr_ack && cmd == 4'b0011, "R6", "ack with activate", {usr_ack, cmd}, 5'h13);
        chk(mem_a == ad[COL_W +: ROW_W] && mem_ba == ad[UADDR_W-1], "R4", "row/bank at activate",
            {mem_ba, mem_a}, {ad[UADDR_W-1], ad[COL_W +: ROW_W]});
        usr_req = 0;
        repeat (3) @(negedge clk);
        chk(cmd == 4'b0100, "R5", "write 3 cycles after activate", cmd, 4'b0100);
        chk(mem_a[10] && mem_a[COL_W-1:0] == ad[COL_W-1:0], "R4", "column + auto-precharge",
            mem_a, {1'b1, 1'b0, ad[COL_W-1:0]});
        chk(mem_dq_oe && mem_dq_out == d, "R7", "write data driven", mem_dq_out, d);
        chk(mem_dqm == ~be, "R7", "write masks", mem_dqm, ~be);
        w = expm.exists(k) ? expm[k] : 64'h0;
        for (int b = 0; b < 8; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
        expm[k] = w;
    endtask

    task automatic t_read(input logic [UADDR_W-1:0] ad);
        int k = int'(ad);
        logic [63:0] e;
        e = expm.exists(k) ? expm[k] : 64'h0;
        @(negedge clk);
        usr_req = 1; usr_we = 0; usr_addr = ad;
        wait_ack();
        chk(mem_a == ad[COL_W +: ROW_W] && mem_ba == ad[UADDR_W-1], "R4", "row/bank at activate",
            {mem_ba, mem_a}, {ad[UADDR_W-1], ad[COL_W +: ROW_W]});
        usr_req = 0;
        repeat (3) @(negedge clk);
        chk(cmd == 4'b0101 && mem_a[10], "R5", "read 3 cycles after activate", {cmd, mem_a[10]}, 5'h0B);
        @(negedge clk);
        chk(mem_dqm == '0, "R8", "read masks open", mem_dqm, 0);
        repeat (2) @(negedge clk);
        chk(!usr_rvalid, "R8", "no early rvalid", usr_rvalid, 0);
        @(negedge clk);
        chk(usr_rvalid && usr_rdata == e, "R8", "read data", usr_rdata, e);
    endtask

    task automatic t_refresh_rate();
        int r0 = ref_cnt;
        repeat (4 * REF_INT) @(negedge clk);
        chk(ref_cnt - r0 >= 3 && ref_cnt - r0 <= 5, "R9", "idle refresh count", ref_cnt - r0, 4);
    endtask

    task automatic t_priority();
        int r0 = ref_cnt;
        int q0 = ref_with_req;
        for (int i = 0; i < 250 && ref_cnt == r0; i++)
            t_write(UADDR_W'(i * 37 + 5), 64'hA5A5_0000_0000_0000 | 64'(i), 8'hFF);
        chk(ref_cnt > r0, "R10", "refresh under traffic", ref_cnt - r0, 1);
        chk(ref_with_req > q0, "R10", "refresh chosen over held request", ref_with_req - q0, 1);
    endtask

    task automatic t_final();
        chk(vio_r3 == 0, "R3", "spacing after mode set", vio_r3, 0);
        chk(vio_r4 == 0, "R4", "auto-precharge violations", vio_r4, 0);
        chk(vio_r5 == 0, "R5", "activate/column spacing violations", vio_r5, 0);
        chk(vio_r6 == 0, "R6", "ack/activate mismatches", vio_r6, 0);
        chk(vio_r7 == 0, "R7", "bus driven outside write", vio_r7, 0);
        chk(vio_r8 == 0, "R8", "rvalid timing violations", vio_r8, 0);
        chk(vio_r9 == 0, "R9", "refresh spacing violations", vio_r9, 0);
        chk(vio_r11 == 0, "R11", "illegal command / cke low", vio_r11, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_init();
        t_write({1'b0, 11'h012, 9'h034}, 64'h1122_3344_5566_7788, 8'hFF);
        t_read({1'b0, 11'h012, 9'h034});
        t_write({1'b0, 11'h012, 9'h034}, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);
        t_read({1'b0, 11'h012, 9'h034});
        t_write({1'b1, 11'h7FF, 9'h1FF}, 64'hDEAD_BEEF_0BAD_F00D, 8'hA5);
        t_read({1'b1, 11'h7FF, 9'h1FF});
        t_read({1'b1, 11'h000, 9'h000});
        t_refresh_rate();
        t_priority();
        t_read({1'b0, 11'h012, 9'h034});
        repeat (20) @(negedge clk);
        t_final();
        finish_run();
    end
endmodule